// File: doc/BRIEF.md
# Packed SIMD Multiplier with Selectable Result Forms

This block multiplies two 32-bit packed operands lane by lane over several clock cycles. The caller chooses a lane width of 8, 16 or 32 bits and whether the lanes are signed or unsigned. The caller also chooses one result form, which applies to every lane: a same-width product clamped to the lane's range, the double-width product, only its upper half, or only its lower half. The double-width form reads only the lower half of the source lanes. Each product it keeps takes two result lanes. A 32-bit double-width product therefore spans both output words.

An operation begins with a one-cycle `start` while the block is idle. `busy` stays high while the operation runs. A one-cycle `done` marks the cycle in which the new result appears on `resLo`/`resHi`. Because the latency is fixed, a pipeline scheduler can reserve the write-back slot at issue time. Internally, the operand magnitudes are multiplied by a shift-and-add over two 16-bit chunks of the multiplier. The sign is restored afterwards.

Top module: `simd_mul`

## Requirements
- R1: After reset, `busy` and `done` are low and `resLo` and `resHi` are zero.
- R2: A `start` sampled at a clock edge while `busy` is low begins an operation. `busy` is high for the next three cycles. `done` is high for exactly one cycle, after the fourth edge counted from the one that sampled `start`, and `busy` is low in that cycle. A `start` in the `done` cycle is accepted.
- R3: A `start` sampled while `busy` is high is ignored. It does not change the running operation's timing or result.
- R4: `laneFmt` 0 selects four 8-bit lanes, 1 selects two 16-bit lanes, and 2 or 3 select one 32-bit lane. Lane i of an operand occupies bits [w*i+w-1 : w*i]. With 8-bit lanes the operands are always unsigned and `signedOp` has no effect.
- R5: `resMode` 3 (low half) puts the low w bits of lane i's product into lane i of `resLo`.
- R6: `resMode` 2 (high half) puts bits [2w-1:w] of lane i's product into lane i of `resLo`. The product is two's complement when signed.
- R7: `resMode` 0 (saturate) with unsigned lanes gives the product, or all ones when the product exceeds 2^w-1.
- R8: `resMode` 0 with signed lanes gives the product, clamped to 2^(w-1)-1 above and to -2^(w-1) below.
- R9: `resMode` 1 (full width) with 8- or 16-bit lanes multiplies only the lower half of the source lanes. It places the 2w-bit product of source lane i at bits [2w*i+2w-1 : 2w*i] of `resLo`.
- R10: `resMode` 1 with the 32-bit lane returns the 64-bit product, with the low word on `resLo` and the high word on `resHi`.
- R11: The outputs change only in a `done` cycle and hold their value between `done` pulses. `resHi` is zero except for a full-width 32-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| opA | input | 32 | Packed multiplicand |
| opB | input | 32 | Packed multiplier |
| laneFmt | input | 2 | Lane width code (0: 8, 1: 16, 2/3: 32) |
| signedOp | input | 1 | Interpret lanes as two's complement |
| resMode | input | 2 | Result form (0 sat, 1 full, 2 high, 3 low) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; the result is new this cycle |
| resLo | output | 32 | Result word, low |
| resHi | output | 32 | Result word, high (full-width 32-bit only) |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any operation. They also assume that the operand, format and mode inputs matter only in the cycle in which `start` is accepted. The bench honours both. It holds reset for several cycles and changes the inputs only on falling edges. It deliberately varies the operands and mode while an operation is running, and it pulses `start` during busy cycles to show that those changes are ignored. The stimulus covers every lane format and result form. It includes the extreme operands that drive saturation both ways and the most negative signed values whose magnitude needs the full lane width.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
  localparam int WORD_W  = 32;
  localparam int ACC_W   = 2 * WORD_W;
  localparam int CHUNK_W = WORD_W / 2;
  localparam int LANES8  = WORD_W / 8;
  localparam int LANES16 = WORD_W / 16;

  localparam logic [1:0] FMT_B8  = 2'd0;
  localparam logic [1:0] FMT_H16 = 2'd1;
  localparam logic [1:0] FMT_W32 = 2'd2;

  localparam logic [1:0] MODE_SAT  = 2'd0;
  localparam logic [1:0] MODE_FULL = 2'd1;
  localparam logic [1:0] MODE_HIGH = 2'd2;
  localparam logic [1:0] MODE_LOW  = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC0, ST_ACC1, ST_FIN} mulState_t;

  typedef struct packed {
    logic capture;
    logic accEn;
    logic accPass;
    logic finish;
  } mulCtl_t;
endpackage

// File: rtl/simd_mul_ctrl.sv
module simd_mul_ctrl
  import simd_mul_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output mulCtl_t ctl,
  output logic    busy,
  output logic    done
);
  mulState_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      case (state)
        ST_IDLE: if (start) state <= ST_ACC0;
        ST_ACC0: state <= ST_ACC1;
        ST_ACC1: state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capture = (state == ST_IDLE) && start;
    ctl.accEn   = (state == ST_ACC0) || (state == ST_ACC1);
    ctl.accPass = (state == ST_ACC1);
    ctl.finish  = (state == ST_FIN);
    busy        = (state != ST_IDLE);
  end

  // R2: done is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: busy is never high together with done
  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2: done follows a busy cycle
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  // R3: a running operation keeps going whatever start does
  a_r3_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctl.finish) |=> busy);
endmodule

// File: rtl/simd_mul_dp.sv
module simd_mul_dp
  import simd_mul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mulCtl_t           ctl,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [1:0]        laneFmt,
  input  logic              signedOp,
  input  logic [1:0]        resMode,
  output logic [WORD_W-1:0] resLo,
  output logic [WORD_W-1:0] resHi
);
  logic [1:0]        fmtQ, modeQ;
  logic              sgnQ;
  logic [WORD_W-1:0] magA, magB, magANext, magBNext;
  logic [LANES8-1:0] negQ, negNext;
  logic [ACC_W-1:0]  acc, accNext;
  logic [1:0]        fmtIn;
  logic              sgnIn;

  assign fmtIn = (laneFmt == 2'd3) ? FMT_W32 : laneFmt;
  assign sgnIn = signedOp && (fmtIn != FMT_B8);

  // magnitude and sign extraction at capture
  always_comb begin
    magANext = opA;
    magBNext = opB;
    negNext  = '0;
    if (sgnIn) begin
      if (fmtIn == FMT_H16) begin
        for (int j = 0; j < LANES16; j++) begin
          if (opA[16*j+15]) magANext[16*j +: 16] = 16'(-opA[16*j +: 16]);
          if (opB[16*j+15]) magBNext[16*j +: 16] = 16'(-opB[16*j +: 16]);
          negNext[j] = opA[16*j+15] ^ opB[16*j+15];
        end
      end else begin
        if (opA[WORD_W-1]) magANext = WORD_W'(-opA);
        if (opB[WORD_W-1]) magBNext = WORD_W'(-opB);
        negNext[0] = opA[WORD_W-1] ^ opB[WORD_W-1];
      end
    end
  end

  // per-lane partial products
  logic [15:0] prod8  [LANES8];
  logic [31:0] prod16 [LANES16];
  genvar gi;
  generate
    for (gi = 0; gi < LANES8; gi++) begin : g_lane8
      assign prod8[gi] = 16'(magA[8*gi +: 8]) * 16'(magB[8*gi +: 8]);
    end
    for (gi = 0; gi < LANES16; gi++) begin : g_lane16
      assign prod16[gi] = 32'(magA[16*gi +: 16]) * 32'(magB[16*gi +: 16]);
    end
  endgenerate

  logic [CHUNK_W-1:0]        chunk;
  logic [WORD_W+CHUNK_W-1:0] partW;
  assign chunk = ctl.accPass ? magB[WORD_W-1:CHUNK_W] : magB[CHUNK_W-1:0];
  assign partW = (WORD_W+CHUNK_W)'(magA) * (WORD_W+CHUNK_W)'(chunk);

  always_comb begin
    accNext = acc;
    case (fmtQ)
      FMT_B8:
        if (!ctl.accPass)
          for (int i = 0; i < LANES8; i++) accNext[16*i +: 16] = prod8[i];
      FMT_H16:
        if (!ctl.accPass)
          for (int j = 0; j < LANES16; j++) accNext[32*j +: 32] = prod16[j];
      default:
        accNext = acc + (ctl.accPass ? {partW, {CHUNK_W{1'b0}}}
                                     : {{CHUNK_W{1'b0}}, partW});
    endcase
  end

  // signed products restored from magnitudes
  logic [31:0]      sp16 [LANES16];
  logic [ACC_W-1:0] sp32;
  generate
    for (gi = 0; gi < LANES16; gi++) begin : g_sign16
      assign sp16[gi] = negQ[gi] ? 32'(-acc[32*gi +: 32]) : acc[32*gi +: 32];
    end
  endgenerate
  assign sp32 = negQ[0] ? ACC_W'(-acc) : acc;

  logic [WORD_W-1:0] finLo, finHi;
  always_comb begin
    finLo = '0;
    finHi = '0;
    case (fmtQ)
      FMT_B8: begin
        for (int i = 0; i < LANES8; i++) begin
          case (modeQ)
            MODE_SAT:  finLo[8*i +: 8] = (|acc[16*i+8 +: 8]) ? 8'hFF : acc[16*i +: 8];
            MODE_HIGH: finLo[8*i +: 8] = acc[16*i+8 +: 8];
            MODE_LOW:  finLo[8*i +: 8] = acc[16*i +: 8];
            default:   if (i < LANES8/2) finLo[16*i +: 16] = acc[16*i +: 16];
          endcase
        end
      end
      FMT_H16: begin
        for (int j = 0; j < LANES16; j++) begin
          case (modeQ)
            MODE_SAT:
              if (sgnQ) begin
                if ((sp16[j][31:15] == '0) || (sp16[j][31:15] == '1))
                  finLo[16*j +: 16] = sp16[j][15:0];
                else
                  finLo[16*j +: 16] = sp16[j][31] ? 16'h8000 : 16'h7FFF;
              end else begin
                finLo[16*j +: 16] = (|sp16[j][31:16]) ? 16'hFFFF : sp16[j][15:0];
              end
            MODE_HIGH: finLo[16*j +: 16] = sp16[j][31:16];
            MODE_LOW:  finLo[16*j +: 16] = sp16[j][15:0];
            default:   if (j == 0) finLo = sp16[0];
          endcase
        end
      end
      default: begin
        case (modeQ)
          MODE_SAT:
            if (sgnQ) begin
              if ((sp32[ACC_W-1:WORD_W-1] == '0) || (sp32[ACC_W-1:WORD_W-1] == '1))
                finLo = sp32[WORD_W-1:0];
              else
                finLo = sp32[ACC_W-1] ? {1'b1, {(WORD_W-1){1'b0}}}
                                      : {1'b0, {(WORD_W-1){1'b1}}};
            end else begin
              finLo = (|sp32[ACC_W-1:WORD_W]) ? '1 : sp32[WORD_W-1:0];
            end
          MODE_HIGH: finLo = sp32[ACC_W-1:WORD_W];
          MODE_LOW:  finLo = sp32[WORD_W-1:0];
          default: begin
            finLo = sp32[WORD_W-1:0];
            finHi = sp32[ACC_W-1:WORD_W];
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmtQ  <= FMT_B8;
      modeQ <= MODE_SAT;
      sgnQ  <= 1'b0;
      magA  <= '0;
      magB  <= '0;
      negQ  <= '0;
      acc   <= '0;
      resLo <= '0;
      resHi <= '0;
    end else begin
      if (ctl.capture) begin
        fmtQ  <= fmtIn;
        modeQ <= resMode;
        sgnQ  <= sgnIn;
        magA  <= magANext;
        magB  <= magBNext;
        negQ  <= negNext;
        acc   <= '0;
      end else if (ctl.accEn) begin
        acc <= accNext;
      end
      if (ctl.finish) begin
        resLo <= finLo;
        resHi <= finHi;
      end
    end
  end

  // R11: outputs hold outside the finishing step
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.finish |=> ($stable(resLo) && $stable(resHi)));
  // R11: upper word only carries a full-width 32-bit product
  a_r11_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.finish && !(fmtQ == FMT_W32 && modeQ == MODE_FULL)) |=> (resHi == '0));
  // R7: an 8-bit lane product above 255 saturates to all ones
  a_r7_u8_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.finish && fmtQ == FMT_B8 && modeQ == MODE_SAT && (|acc[15:8]))
      |=> (resLo[7:0] == 8'hFF));
  // R4: 8-bit lanes never carry a negative sign
  a_r4_u8_no_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.accEn && fmtQ == FMT_B8) |-> (negQ == '0 && !sgnQ));
endmodule

// File: rtl/simd_mul.sv
module simd_mul
  import simd_mul_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  laneFmt,
  input  logic        signedOp,
  input  logic [1:0]  resMode,
  output logic        busy,
  output logic        done,
  output logic [31:0] resLo,
  output logic [31:0] resHi
);
  mulCtl_t ctl;

  simd_mul_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  simd_mul_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .laneFmt  (laneFmt),
    .signedOp (signedOp),
    .resMode  (resMode),
    .resLo    (resLo),
    .resHi    (resHi)
  );
endmodule

// File: tb/simd_mul_test.sv
`timescale 1ns/1ps
module simd_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  laneFmt = '0, resMode = '0;
  logic        signedOp = 1'b0;
  logic        busy, done;
  logic [31:0] resLo, resHi;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tagIn = "R5";

  always #2.5 clk = ~clk;

  simd_mul uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opA(opA), .opB(opB),
    .laneFmt(laneFmt), .signedOp(signedOp), .resMode(resMode),
    .busy(busy), .done(done), .resLo(resLo), .resHi(resHi)
  );

  // behavioural reference of the packed product
  function automatic logic [63:0] refMul(input logic [31:0] a, input logic [31:0] b,
                                         input logic [1:0] f, input logic s,
                                         input logic [1:0] m);
    int w, nl, keep;
    logic es;
    logic [63:0] res, mask, mask2;
    res  = '0;
    w    = (f == 2'd0) ? 8 : (f == 2'd1) ? 16 : 32;
    nl   = 32 / w;
    keep = (nl / 2 > 0) ? nl / 2 : 1;
    es   = s && (w != 8);
    mask  = (64'd1 << w) - 64'd1;
    mask2 = (w == 32) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
    for (int i = 0; i < nl; i++) begin
      logic [63:0] ua, ub, r;
      logic signed [65:0] sa, sb, p, hiL, loL;
      ua = (64'(a) >> (w * i)) & mask;
      ub = (64'(b) >> (w * i)) & mask;
      sa = $signed({2'b00, ua});
      sb = $signed({2'b00, ub});
      if (es && ua[w-1]) sa = sa - (66'sd1 <<< w);
      if (es && ub[w-1]) sb = sb - (66'sd1 <<< w);
      p = sa * sb;
      if (es) begin
        hiL = (66'sd1 <<< (w - 1)) - 66'sd1;
        loL = -(66'sd1 <<< (w - 1));
      end else begin
        hiL = (66'sd1 <<< w) - 66'sd1;
        loL = 66'sd0;
      end
      case (m)
        2'd0: begin
          if (p > hiL) r = hiL[63:0];
          else if (p < loL) r = loL[63:0];
          else r = p[63:0];
          res |= (r & mask) << (w * i);
        end
        2'd2: res |= ((p[63:0] >> w) & mask) << (w * i);
        2'd3: res |= (p[63:0] & mask) << (w * i);
        default: if (i < keep) res |= (p[63:0] & mask2) << (2 * w * i);
      endcase
    end
    return res;
  endfunction

  // cycle model of timing and result registers
  int          cnt = 0;
  bit          mDone = 0;
  bit          anyDone = 0;
  logic [63:0] pend = '0, expRes = '0;
  string       pendTag = "R1", resTag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt = 0; mDone = 0; expRes = '0;
    end else begin
      mDone = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mDone = 1; anyDone = 1; expRes = pend; resTag = pendTag;
        end
      end else if (start) begin
        cnt = 3;
        pend = refMul(opA, opB, laneFmt, signedOp, resMode);
        pendTag = tagIn;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string t;
      t = (mDone || !anyDone) ? resTag : "R11";
      checks++;
      if (busy !== (cnt > 0)) begin
        errors++; $display("FAIL R2 busy: actual %0b expected %0b", busy, cnt > 0);
      end
      checks++;
      if (done !== mDone) begin
        errors++; $display("FAIL R2 done: actual %0b expected %0b", done, mDone);
      end
      checks++;
      if ({resHi, resLo} !== expRes) begin
        errors++;
        $display("FAIL %s result: actual %h_%h expected %h", t, resHi, resLo, expRes);
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [1:0] f,
                       input logic s, input logic [1:0] m, input string tg);
    @(negedge clk);
    opA = a; opB = b; laneFmt = f; signedOp = s; resMode = m; tagIn = tg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opA = ~a; opB = b ^ 32'h5A5A_A5A5; resMode = ~m;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R5 low half, 8-bit unsigned
    issue(32'h1234_5678, 32'h9ABC_DEF0, 2'd0, 1'b0, 2'd3, "R5");
    // R6 high half, 16-bit signed
    issue(32'h8000_FFFF, 32'h7FFF_0003, 2'd1, 1'b1, 2'd2, "R6");
    // R7 unsigned saturate, 8 and 32 bit
    issue(32'hFF10_0F02, 32'h0210_1181, 2'd0, 1'b0, 2'd0, "R7");
    issue(32'h0001_0000, 32'h0001_0000, 2'd2, 1'b0, 2'd0, "R7");
    // R8 signed saturate both directions
    issue(32'h7FFF_8000, 32'h0002_0002, 2'd1, 1'b1, 2'd0, "R8");
    issue(32'h8000_0000, 32'h8000_0000, 2'd2, 1'b1, 2'd0, "R8");
    issue(32'h8000_0000, 32'h0000_0002, 2'd2, 1'b1, 2'd0, "R8");
    // R9 full width 8-bit and 16-bit
    issue(32'hAAAA_FF80, 32'h5555_FF03, 2'd0, 1'b0, 2'd1, "R9");
    issue(32'h1111_8000, 32'h2222_8000, 2'd1, 1'b1, 2'd1, "R9");
    // R10 full width 32-bit
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 1'b0, 2'd1, "R10");
    issue(32'hFFFF_FFFF, 32'h7FFF_FFFF, 2'd3, 1'b1, 2'd1, "R10");
    // R4 signed flag ignored on 8-bit lanes; code 3 acts as 32-bit
    issue(32'h80FF_7F01, 32'hFF80_02FF, 2'd0, 1'b1, 2'd2, "R4");
    issue(32'h8765_4321, 32'h0000_1234, 2'd3, 1'b1, 2'd3, "R4");
    // R3 start while busy is ignored
    @(negedge clk);
    opA = 32'h0003_0005; opB = 32'h0007_0009; laneFmt = 2'd1; signedOp = 1'b0;
    resMode = 2'd3; tagIn = "R3"; start = 1'b1;
    @(negedge clk);
    opA = 32'hFFFF_FFFF; opB = 32'hFFFF_FFFF; resMode = 2'd1; laneFmt = 2'd2;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    // R11 idle gap: results hold
    repeat (6) @(negedge clk);
    // mixed operations back to back (start lands in done cycle, R2)
    for (int k = 0; k < 300; k++) begin
      logic [1:0] f, m;
      logic s;
      string tg;
      f = 2'($urandom_range(0, 3));
      m = 2'($urandom_range(0, 3));
      s = 1'($urandom_range(0, 1));
      case (m)
        2'd0: tg = (s && f != 2'd0) ? "R8" : "R7";
        2'd1: tg = (f[1]) ? "R10" : "R9";
        2'd2: tg = "R6";
        default: tg = "R5";
      endcase
      issue($urandom, $urandom, f, s, m, tg);
      if (k % 37 == 0) repeat (3) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule